// File: doc/BRIEF.md
# DMA Interrupt and Channel-Enable Register Bank

This block is the control and status register bank that sits beside a multi-channel DMA engine. The engine sends it a one-cycle pulse for each channel event. There are five event classes: whole-transfer done, block done, source-side transaction, destination-side transaction and error. The bank latches each pulse as a sticky flag for that channel and class. For every class, software gets four register views:

- raw flags, read-only;
- masked status, read-only;
- a mask, read/write;
- a write-only acknowledge.

A one-word summary register reports which classes have anything pending and unmasked. A single interrupt line goes high when that summary is non-zero and the global DMA enable is on.

Every access goes through a 32-bit register port. A write takes effect on the clock edge where the write strobe is sampled. A read returns its data on the clock edge after the read strobe.

Mask, acknowledge and channel-enable writes are lane-selective. The low byte of the write data carries new bit values and the next byte carries a per-bit update enable. Software can therefore change one channel without reading the register first.

Each class register occupies an 8-byte slot: a low word holding the bits, and a high word that always reads zero. The slots of one view are consecutive in class order. The class number therefore selects the slot.

Top module: `dma_irq_regbank`

## Requirements
- R1: After reset every flag, mask, the global enable and the channel-enable register are zero, the interrupt output is low and the read data is zero.
- R2: An event pulse on channel c of a class sets that class's raw flag bit c on the same clock edge, whether the bit is masked or not. The raw view of class k (0 transfer, 1 block, 2 source, 3 destination, 4 error) is read at byte offset 0x2C0 + 8k. Raw bits are never set by anything but an event.
- R3: The status view of class k at 0x2E8 + 8k reads as that class's raw flags ANDed with its mask. A write to a raw or status address changes nothing.
- R4: The mask of class k at 0x310 + 8k reads back its value. A 1 enables the channel. A write changes mask bit c to write-data bit c only where write-data bit 8+c is 1.
- R5: A write to the acknowledge address of class k at 0x338 + 8k clears raw bit c only when both write-data bit c and bit 8+c are 1. Reading that address returns zero.
- R6: If an event pulse and an acknowledge hit the same raw bit in one cycle, the flag stays set.
- R7: The summary register at 0x360 has bit k set exactly when class k has at least one raw bit whose mask bit is 1.
- R8: The interrupt output is high exactly when the global enable is 1 and the summary is non-zero.
- R9: The global enable is bit 0 of the register at 0x398. The channel-enable register at 0x3A0 takes lane-selective writes (data in bits [7:0], per-bit update enable in bits [15:8]) only while the global enable is 1. While the enable is 0 it ignores such writes.
- R10: Writing 0 to the global enable forces every channel-enable bit to zero.
- R11: Bits for channels at or above the configured channel count read as zero and ignore writes and acknowledges.
- R12: Read data changes only on the edge after a read strobe and otherwise holds. The high word of any 8-byte slot, and any unmapped address, reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data; lane-selective registers use [7:0] data and [15:8] update enables |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ev_xfer_done | input | NUM_CH | Per-channel transfer-complete pulses |
| ev_blk_done | input | NUM_CH | Per-channel block-complete pulses |
| ev_src_txn | input | NUM_CH | Per-channel source-transaction pulses |
| ev_dst_txn | input | NUM_CH | Per-channel destination-transaction pulses |
| ev_err | input | NUM_CH | Per-channel error pulses |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the bank with six channels, below the eight-lane register width. Lanes 6 and 7 then exist in the write format but not in the design, so the rule that absent channels read zero and drop writes becomes observable. With six channels, every class and channel position can be swept one at a time, covering each 8-byte slot of each view. Masks, acknowledges and channel enables are driven with partial update-enable bytes and with data bits set outside the enabled lanes. Expected register values come from masking arithmetic in the bench.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants, decode types and the lane-merge helper for
// the DMA interrupt register bank. Assumes at most 8 channels (one byte lane).
package dma_irq_pkg;

    localparam int NUM_CLASS    = 5;
    localparam int LANE_W       = 8;
    localparam int SLOT_STRIDE  = 8;

    // Byte offsets; class k of a view sits at base + SLOT_STRIDE*k
    localparam int RAW_BASE     = 'h2C0;
    localparam int STAT_BASE    = 'h2E8;
    localparam int MASK_BASE    = 'h310;
    localparam int ACK_BASE     = 'h338;
    localparam int SUMMARY_ADDR = 'h360;
    localparam int GLOBAL_ADDR  = 'h398;
    localparam int CHEN_ADDR    = 'h3A0;

    typedef enum logic [2:0] {
        VIEW_NONE,
        VIEW_RAW,
        VIEW_STAT,
        VIEW_MASK,
        VIEW_ACK,
        VIEW_SUMMARY,
        VIEW_GLOBAL,
        VIEW_CHEN
    } view_e;

    typedef struct packed {
        view_e      view;
        logic [2:0] cls;
        logic       hi_word;
    } dec_t;

    // Replace the bits of old_v selected by upd with the matching bits of new_v
    function automatic logic [LANE_W-1:0] lane_merge(
        input logic [LANE_W-1:0] old_v,
        input logic [LANE_W-1:0] new_v,
        input logic [LANE_W-1:0] upd
    );
        return (old_v & ~upd) | (new_v & upd);
    endfunction

endpackage

// File: rtl/dma_irq_addr_dec.sv
// Address decoder: maps a byte address onto a register view, a class index
// and a high-word flag. Purely combinational. Assumes all slot bases are
// 8-byte aligned and that accesses are word aligned (addr[1:0] == 0).
module dma_irq_addr_dec
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    logic [ADDR_W-1:0] slot_addr;

    // Strip the word-within-slot bit so a slot and its high word share a base
    assign slot_addr = {addr[ADDR_W-1:3], 3'b000};

    // Look the slot address up against every view and class
    always_comb begin
        dec         = '{view: VIEW_NONE, cls: 3'd0, hi_word: addr[2]};
        if (addr[1:0] == 2'b00) begin
            for (int k = 0; k < NUM_CLASS; k++) begin
                if (slot_addr == ADDR_W'(RAW_BASE + SLOT_STRIDE * k)) begin
                    dec.view = VIEW_RAW;
                    dec.cls  = 3'(k);
                end
                if (slot_addr == ADDR_W'(STAT_BASE + SLOT_STRIDE * k)) begin
                    dec.view = VIEW_STAT;
                    dec.cls  = 3'(k);
                end
                if (slot_addr == ADDR_W'(MASK_BASE + SLOT_STRIDE * k)) begin
                    dec.view = VIEW_MASK;
                    dec.cls  = 3'(k);
                end
                if (slot_addr == ADDR_W'(ACK_BASE + SLOT_STRIDE * k)) begin
                    dec.view = VIEW_ACK;
                    dec.cls  = 3'(k);
                end
            end
            if (slot_addr == ADDR_W'(SUMMARY_ADDR)) dec.view = VIEW_SUMMARY;
            if (slot_addr == ADDR_W'(GLOBAL_ADDR))  dec.view = VIEW_GLOBAL;
            if (slot_addr == ADDR_W'(CHEN_ADDR))    dec.view = VIEW_CHEN;
        end
    end

endmodule

// File: rtl/dma_irq_class_cell.sv
// Class cell: sticky raw flags and the mask for one interrupt class.
// Events set flags; lane-selective acknowledges clear them, and an event
// arriving with an acknowledge wins. Assumes NUM_CH <= 8.
module dma_irq_class_cell
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   ev,
    input  logic                mask_wr,
    input  logic                ack_wr,
    input  logic [LANE_W-1:0]   wr_bits,
    input  logic [LANE_W-1:0]   wr_upd,
    output logic [NUM_CH-1:0]   raw,
    output logic [NUM_CH-1:0]   mask,
    output logic                pend
);

    logic [LANE_W-1:0] mask_wide;
    logic [LANE_W-1:0] mask_merged;
    logic [LANE_W-1:0] ack_wide;
    logic [NUM_CH-1:0] ack_lanes;

    // Widen the mask to a full lane and merge in the selected write bits
    always_comb begin
        mask_wide               = '0;
        mask_wide[NUM_CH-1:0]   = mask;
        mask_merged             = lane_merge(mask_wide, wr_bits, wr_upd);
    end

    // Acknowledge bits: both data and update enable must be set
    always_comb begin
        ack_wide  = ack_wr ? (wr_bits & wr_upd) : '0;
        ack_lanes = ack_wide[NUM_CH-1:0];
    end

    // Raw flags: clear acknowledged bits, then OR in new events (event wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= '0;
        end else begin
            raw <= (raw & ~ack_lanes) | ev;
        end
    end

    // Mask register: lane-selective update on a mask write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_wr) begin
            mask <= mask_merged[NUM_CH-1:0];
        end
    end

    assign pend = |(raw & mask);

endmodule

// File: rtl/dma_irq_chan_en.sv
// Enable block: holds the global DMA enable and the per-channel enables.
// Channel enables accept lane-selective writes only while the global
// enable is set, and are forced to zero when it is written to 0.
module dma_irq_chan_en
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                global_wr,
    input  logic                chen_wr,
    input  logic [LANE_W-1:0]   wr_bits,
    input  logic [LANE_W-1:0]   wr_upd,
    output logic                dma_en,
    output logic [NUM_CH-1:0]   chen
);

    logic [LANE_W-1:0] chen_wide;
    logic [LANE_W-1:0] chen_merged;

    // Widen and merge the channel enables with the selected write bits
    always_comb begin
        chen_wide             = '0;
        chen_wide[NUM_CH-1:0] = chen;
        chen_merged           = lane_merge(chen_wide, wr_bits, wr_upd);
    end

    // Global enable bit: written from data bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en <= 1'b0;
        end else if (global_wr) begin
            dma_en <= wr_bits[0];
        end
    end

    // Channel enables: forced off with the global enable, else lane update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chen <= '0;
        end else if (global_wr && !wr_bits[0]) begin
            chen <= '0;
        end else if (chen_wr && dma_en) begin
            chen <= chen_merged[NUM_CH-1:0];
        end
    end

endmodule

// File: rtl/dma_irq_rd_mux.sv
// Read path: selects the addressed view and registers it on a read strobe.
// Data holds between reads. High words, acknowledge addresses and unmapped
// addresses return zero.
module dma_irq_rd_mux
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd,
    input  dec_t                        dec,
    input  logic [NUM_CLASS*NUM_CH-1:0] raw_all,
    input  logic [NUM_CLASS*NUM_CH-1:0] mask_all,
    input  logic [NUM_CLASS-1:0]        summary,
    input  logic                        dma_en,
    input  logic [NUM_CH-1:0]           chen,
    output logic [DATA_W-1:0]           rdata
);

    logic [NUM_CH-1:0] raw_sel;
    logic [NUM_CH-1:0] mask_sel;
    logic [DATA_W-1:0] word;

    // Pick the addressed class out of the packed flag and mask vectors
    always_comb begin
        raw_sel  = '0;
        mask_sel = '0;
        for (int k = 0; k < NUM_CLASS; k++) begin
            if (dec.cls == 3'(k)) begin
                raw_sel  = raw_all[k*NUM_CH +: NUM_CH];
                mask_sel = mask_all[k*NUM_CH +: NUM_CH];
            end
        end
    end

    // Form the read word for the decoded view
    always_comb begin
        word = '0;
        if (!dec.hi_word) begin
            unique case (dec.view)
                VIEW_RAW:     word[NUM_CH-1:0]    = raw_sel;
                VIEW_STAT:    word[NUM_CH-1:0]    = raw_sel & mask_sel;
                VIEW_MASK:    word[NUM_CH-1:0]    = mask_sel;
                VIEW_SUMMARY: word[NUM_CLASS-1:0] = summary;
                VIEW_GLOBAL:  word[0]             = dma_en;
                VIEW_CHEN:    word[NUM_CH-1:0]    = chen;
                default:      word                = '0;
            endcase
        end
    end

    // Read data register: loads on a read strobe, otherwise holds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= word;
        end
    end

endmodule

// File: rtl/dma_irq_regbank.sv
// Top: DMA interrupt and channel-enable register bank. Five class cells
// (transfer, block, source, destination, error) latch engine event pulses.
// The summary of pending unmasked classes drives the interrupt line,
// gated by the global enable. Assumes 1 <= NUM_CH <= 8 and
// single-cycle bus strobes.
module dma_irq_regbank
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ev_xfer_done,
    input  logic [NUM_CH-1:0] ev_blk_done,
    input  logic [NUM_CH-1:0] ev_src_txn,
    input  logic [NUM_CH-1:0] ev_dst_txn,
    input  logic [NUM_CH-1:0] ev_err,
    output logic              irq
);

    localparam int FLAG_W = NUM_CLASS * NUM_CH;

    dec_t                 dec;
    logic                 wr_low;
    logic [LANE_W-1:0]    wr_bits;
    logic [LANE_W-1:0]    wr_upd;
    logic [FLAG_W-1:0]    ev_all;
    logic [FLAG_W-1:0]    raw_all;
    logic [FLAG_W-1:0]    mask_all;
    logic [NUM_CLASS-1:0] summary;
    logic                 dma_en;
    logic [NUM_CH-1:0]    chen;
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata[31:16];

    // Split the write word into data lane and per-bit update lane
    assign wr_bits = bus_wdata[7:0];
    assign wr_upd  = bus_wdata[15:8];
    assign wr_low  = bus_wr && !dec.hi_word;

    // Class k occupies bits [k*NUM_CH +: NUM_CH] of the packed event vector
    assign ev_all = {ev_err, ev_dst_txn, ev_src_txn, ev_blk_done, ev_xfer_done};

    dma_irq_addr_dec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar k = 0; k < NUM_CLASS; k++) begin : g_class
        logic mask_wr_k;
        logic ack_wr_k;

        // Steer mask and acknowledge writes to this class only
        assign mask_wr_k = wr_low && (dec.view == VIEW_MASK) && (dec.cls == 3'(k));
        assign ack_wr_k  = wr_low && (dec.view == VIEW_ACK)  && (dec.cls == 3'(k));

        dma_irq_class_cell #(
            .NUM_CH (NUM_CH)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (ev_all[k*NUM_CH +: NUM_CH]),
            .mask_wr (mask_wr_k),
            .ack_wr  (ack_wr_k),
            .wr_bits (wr_bits),
            .wr_upd  (wr_upd),
            .raw     (raw_all[k*NUM_CH +: NUM_CH]),
            .mask    (mask_all[k*NUM_CH +: NUM_CH]),
            .pend    (summary[k])
        );
    end

    dma_irq_chan_en #(
        .NUM_CH (NUM_CH)
    ) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .global_wr (wr_low && (dec.view == VIEW_GLOBAL)),
        .chen_wr   (wr_low && (dec.view == VIEW_CHEN)),
        .wr_bits   (wr_bits),
        .wr_upd    (wr_upd),
        .dma_en    (dma_en),
        .chen      (chen)
    );

    dma_irq_rd_mux #(
        .NUM_CH (NUM_CH),
        .DATA_W (32)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .dec      (dec),
        .raw_all  (raw_all),
        .mask_all (mask_all),
        .summary  (summary),
        .dma_en   (dma_en),
        .chen     (chen),
        .rdata    (bus_rdata)
    );

    // Combined interrupt: any pending unmasked class, gated by global enable
    assign irq = dma_en && (|summary);

endmodule

// File: rtl/dma_irq_regbank_chk.sv
// Checker: temporal properties of the register bank, bound to the top.
// Assumes the synchronous active-low reset is held for at least one edge.
module dma_irq_regbank_chk #(
    parameter int NUM_CH = 8,
    parameter int FLAG_W = 5 * NUM_CH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [FLAG_W-1:0] ev_all,
    input logic [FLAG_W-1:0] raw_all,
    input logic [FLAG_W-1:0] mask_all,
    input logic              dma_en,
    input logic [NUM_CH-1:0] chen,
    input logic              irq
);

    AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_all) |=> ((raw_all & $past(ev_all)) == $past(ev_all)));  // R6

    AST_RAW_ONLY_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_all & ~$past(raw_all) & ~$past(ev_all)) == '0));  // R2

    AST_RAW_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(raw_all) & ~raw_all) == '0) || $past(bus_wr)));  // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !irq);  // R8

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(raw_all & mask_all)));  // R8

    AST_CHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> (chen == '0));  // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));  // R12

endmodule

bind dma_irq_regbank dma_irq_regbank_chk #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ev_all    (ev_all),
    .raw_all   (raw_all),
    .mask_all  (mask_all),
    .dma_en    (dma_en),
    .chen      (chen),
    .irq       (irq)
);

// File: tb/tb_dma_irq_regbank.sv
module tb_dma_irq_regbank;

    localparam int NCH = 6;
    localparam int AW  = 12;
    localparam logic [5:0] CHM = 6'h3F;

    localparam int RAW  = 'h2C0;
    localparam int STA  = 'h2E8;
    localparam int MSK  = 'h310;
    localparam int ACK  = 'h338;
    localparam int SUMA = 'h360;
    localparam int GLB  = 'h398;
    localparam int CHE  = 'h3A0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [NCH-1:0] ev [5];
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [5:0] m_raw [5];
    logic [5:0] m_mask [5];
    logic       m_en;
    logic [5:0] m_chen;

    always #10 clk = ~clk;

    dma_irq_regbank #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ev_xfer_done (ev[0]),
        .ev_blk_done  (ev[1]),
        .ev_src_txn   (ev[2]),
        .ev_dst_txn   (ev[3]),
        .ev_err       (ev[4]),
        .irq          (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int c, input logic [5:0] m);
        @(negedge clk);
        ev[c] = m;
        @(negedge clk);
        ev[c] = '0;
    endtask

    function automatic logic [31:0] summary_exp();
        logic [31:0] s = '0;
        for (int c = 0; c < 5; c++) s[c] = |(m_raw[c] & m_mask[c]);
        return s;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  pat;
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int c = 0; c < 5; c++) begin ev[c] = '0; m_raw[c] = '0; m_mask[c] = '0; end
        m_en = 1'b0; m_chen = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every view
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        for (int c = 0; c < 5; c++) begin
            rd(RAW + 8*c, d); check("R1 raw", d, 32'h0);
            rd(STA + 8*c, d); check("R1 status", d, 32'h0);
            rd(MSK + 8*c, d); check("R1 mask", d, 32'h0);
        end
        rd(SUMA, d); check("R1 summary", d, 32'h0);
        rd(GLB, d);  check("R1 global", d, 32'h0);
        rd(CHE, d);  check("R1 chen", d, 32'h0);

        // R2: every class and channel latches while masked off; R3 status stays 0
        for (int c = 0; c < 5; c++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                pulse(c, 6'(1 << ch));
                m_raw[c] |= 6'(1 << ch);
                rd(RAW + 8*c, d); check("R2 raw latch", d, {26'h0, m_raw[c]});
                rd(STA + 8*c, d); check("R3 status masked", d, {26'h0, m_raw[c] & m_mask[c]});
            end
        end

        // R4/R11: full then partial lane-selective mask writes
        for (int c = 0; c < 5; c++) begin
            pat = 8'hA5 ^ 8'(c * 19);
            wr(MSK + 8*c, {16'h0, 8'hFF, pat});
            m_mask[c] = pat[5:0];
            rd(MSK + 8*c, d); check("R11 mask width", d, {26'h0, m_mask[c]});
            wr(MSK + 8*c, {16'h0, 8'h0F, ~pat});
            m_mask[c] = (m_mask[c] & ~6'h0F) | (~pat[5:0] & 6'h0F);
            rd(MSK + 8*c, d); check("R4 mask partial", d, {26'h0, m_mask[c]});
            rd(STA + 8*c, d); check("R3 status", d, {26'h0, m_raw[c] & m_mask[c]});
        end

        // R7/R8: summary and enable gating
        rd(SUMA, d); check("R7 summary", d, summary_exp());
        check("R8 irq off", {31'h0, irq}, 32'h0);
        wr(GLB, 32'h1); m_en = 1'b1;
        check("R8 irq on", {31'h0, irq}, {31'h0, |summary_exp()});

        // R5: acknowledge needs both data and update bit
        for (int c = 0; c < 5; c++) begin
            wr(ACK + 8*c, {16'h0, 8'h1F, 8'h35});
            m_raw[c] &= ~6'h15;
            rd(RAW + 8*c, d); check("R5 ack partial", d, {26'h0, m_raw[c]});
            rd(ACK + 8*c, d); check("R5 ack reads 0", d, 32'h0);
        end
        rd(SUMA, d); check("R7 summary after ack", d, summary_exp());

        // R3: writes to raw and status views are ignored
        wr(RAW + 8, 32'h0000FF00);
        wr(STA + 8, 32'h0000FFFF);
        rd(RAW + 8, d); check("R3 raw write ignored", d, {26'h0, m_raw[1]});

        for (int c = 0; c < 5; c++) begin
            wr(ACK + 8*c, 32'h0000FFFF);
            m_raw[c] = '0;
        end
        rd(SUMA, d); check("R7 summary clear", d, 32'h0);
        check("R8 irq clear", {31'h0, irq}, 32'h0);

        // R6: event and acknowledge on the same bit in the same cycle
        @(negedge clk);
        ev[1] = 6'h08; bus_wr = 1'b1; bus_addr = AW'(ACK + 8); bus_wdata = 32'h0000FFFF;
        @(negedge clk);
        ev[1] = '0; bus_wr = 1'b0;
        rd(RAW + 8, d); check("R6 event wins", d, 32'h08);
        wr(ACK + 8, 32'h0000FFFF);
        rd(RAW + 8, d); check("R6 later ack", d, 32'h0);

        // R9/R11: channel enables under the global enable
        wr(CHE, {16'h0, 8'h03, 8'hFF}); m_chen = 6'h03;
        rd(CHE, d); check("R9 chen set", d, {26'h0, m_chen});
        wr(CHE, {16'h0, 8'h01, 8'h00}); m_chen = 6'h02;
        rd(CHE, d); check("R9 chen partial", d, {26'h0, m_chen});
        wr(CHE, {16'h0, 8'hC0, 8'hFF});
        rd(CHE, d); check("R11 chen unused lanes", d, {26'h0, m_chen});
        rd(GLB, d); check("R9 global read", d, 32'h1);

        // R10: dropping the global enable clears channel enables
        wr(GLB, 32'h0); m_en = 1'b0; m_chen = '0;
        rd(CHE, d); check("R10 chen forced off", d, 32'h0);
        rd(GLB, d); check("R10 global off", d, 32'h0);
        wr(CHE, 32'h0000FFFF);
        rd(CHE, d); check("R9 chen write while off", d, 32'h0);

        // R12: high words, unmapped space, read-data hold
        pulse(0, 6'h21); m_raw[0] = 6'h21;
        rd(RAW + 4, d);  check("R12 high word", d, 32'h0);
        rd(MSK + 12, d); check("R12 mask high word", d, 32'h0);
        rd('h000, d);    check("R12 unmapped", d, 32'h0);
        rd(RAW, d);      check("R12 raw read", d, 32'h21);
        pulse(0, 6'h02);
        check("R12 rdata holds", bus_rdata, 32'h21);
        rd(RAW, d);      check("R12 fresh read", d, 32'h23);

        finish_run();
    end

endmodule